// File: doc/BRIEF.md
# Banked Pin Controller with Interrupt Flags

This block drives and samples 32 general-purpose pins, arranged as four banks of eight, through a synchronous register port. Each bank has its own 64-byte address window. In that window the bank keeps a direction register, an output latch and a read-only view of its synchronised inputs. It also has an interrupt unit with per-pin masking, per-pin trigger selection and status flags that are cleared by writing ones.

Software picks a pin's direction and output value, reads its input, and arms an interrupt by choosing edge or level triggering and clearing the pin's mask bit. The pad ring takes the direction and output vectors to control each pad's tristate buffer. One combined request line rises whenever any pin has an unmasked pending flag. Reads are combinational: `rd_data` follows `addr` in the same cycle.

Top module: `pinbank_ctrl`

## Requirements
- R1: Pin n belongs to bank n/8 at bit n%8. Address bits [7:6] select the bank and bits [5:0] select the register inside that bank's window.
- R2: After reset, every pin is an input (`pin_dir` all ones) and `pin_out` is zero. Every mask bit reads 1, every status flag reads 0, every pin is in edge mode, and `irq` is low.
- R3: The direction register at offset 0x10 can be read and written. A bit value of 1 makes the pin an input and 0 makes it an output. The register drives `pin_dir` in the cycle after the write.
- R4: The output latch at offset 0x14 can be read and written. It drives `pin_out` in the cycle after the write.
- R5: Offset 0x18 returns the pin inputs after a two-flop synchroniser. A change on `pin_in` shows there after two clock edges. Writes to this offset are ignored.
- R6: When a pin's trigger bit is 0, its status flag sets on a rising edge of the synchronised input. The flag then holds until it is cleared. A flag cleared while the input stays high stays clear.
- R7: The trigger register at offset 0x20 can be read and written. A bit value of 1 makes the pin level-sensitive: its flag is set in every cycle that the synchronised input is high, so clearing it has no lasting effect while the input stays high.
- R8: Offset 0x04 reads the raw status flags. Writing ones there clears those flags. If a clear and a new event hit the same bit in the same cycle, the event wins.
- R9: Writing ones to offset 0x0C sets those mask bits. Writing ones to offset 0x08 clears them. Reading offset 0x08 returns the mask. Offset 0x0C always reads zero.
- R10: Offset 0x00 is read-only and returns the raw status AND NOT the mask.
- R11: `irq` is the OR of all 32 masked status bits, taken across the four banks.
- R12: Unmapped offsets read zero, and writes to read-only or unmapped offsets change nothing. `rd_data[31:8]` always reads zero, and `wr_data[31:8]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address (bank, offset) |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 32 | Write data; only bits [7:0] are used |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Raw pad inputs (asynchronous) |
| pin_dir | output | 32 | Per-pin direction, 1 = input |
| pin_out | output | 32 | Per-pin output value |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets several corner cases:
- Clearing an edge-mode flag while its pin stays high. A design that treated edge mode as level would re-raise the flag.
- Clearing a level-mode flag under a held-high input. A design that gave the clear priority would let the flag drop for a cycle.
- The separate set-mask and clear-mask offsets. Swapping them would invert the `irq` response.
- The bank field of the address. A decode fault would move a write into a neighbouring bank's pads.
- The two-cycle input latency and writes to read-only or unmapped offsets. These catch a design that skips a synchroniser stage or lets a stray write reach a register.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Width of the offset field inside one bank window (64-byte window)
    localparam int unsigned OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_PEND     = 6'h00;
    localparam logic [OFF_W-1:0] OFF_FLAGS    = 6'h04;
    localparam logic [OFF_W-1:0] OFF_MASK_CLR = 6'h08;
    localparam logic [OFF_W-1:0] OFF_MASK_SET = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_DIR      = 6'h10;
    localparam logic [OFF_W-1:0] OFF_DRIVE    = 6'h14;
    localparam logic [OFF_W-1:0] OFF_SENSE    = 6'h18;
    localparam logic [OFF_W-1:0] OFF_TRIG     = 6'h20;

    typedef enum logic [3:0] {
        SEL_PEND,
        SEL_FLAGS,
        SEL_MASK_CLR,
        SEL_MASK_SET,
        SEL_DIR,
        SEL_DRIVE,
        SEL_SENSE,
        SEL_TRIG,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        case (off)
            OFF_PEND:     return SEL_PEND;
            OFF_FLAGS:    return SEL_FLAGS;
            OFF_MASK_CLR: return SEL_MASK_CLR;
            OFF_MASK_SET: return SEL_MASK_SET;
            OFF_DIR:      return SEL_DIR;
            OFF_DRIVE:    return SEL_DRIVE;
            OFF_SENSE:    return SEL_SENSE;
            OFF_TRIG:     return SEL_TRIG;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) chain_q[i] <= '0;
            else        chain_q[i] <= chain_d[i];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [LANES-1:0] wr_bits,
    input  logic [LANES-1:0] sync_in,
    output logic [LANES-1:0] dir_o,
    output logic [LANES-1:0] drive_o,
    output logic [LANES-1:0] pend_o,
    output logic [LANES-1:0] rd_o
);

    typedef struct packed {
        logic [LANES-1:0] dir;
        logic [LANES-1:0] drive;
        logic [LANES-1:0] mask;
        logic [LANES-1:0] flag;
        logic [LANES-1:0] trig;
        logic [LANES-1:0] last;
    } bank_state_t;

    bank_state_t st_q, st_d;
    logic [LANES-1:0] event_d;
    logic [LANES-1:0] clear_d;

    always_comb begin
        st_d    = st_q;
        clear_d = '0;
        // Edge lanes fire on a 0->1 of the synchronised input, level lanes while high
        event_d = (sync_in & ~st_q.last & ~st_q.trig) | (sync_in & st_q.trig);
        if (wr_en) begin
            case (sel)
                SEL_FLAGS:    clear_d     = wr_bits;
                SEL_MASK_CLR: st_d.mask   = st_q.mask & ~wr_bits;
                SEL_MASK_SET: st_d.mask   = st_q.mask | wr_bits;
                SEL_DIR:      st_d.dir    = wr_bits;
                SEL_DRIVE:    st_d.drive  = wr_bits;
                SEL_TRIG:     st_d.trig   = wr_bits;
                default:      ;
            endcase
        end
        // A new event in the same cycle as a clear keeps the flag set
        st_d.flag = (st_q.flag & ~clear_d) | event_d;
        st_d.last = sync_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dir   <= '1;
            st_q.drive <= '0;
            st_q.mask  <= '1;
            st_q.flag  <= '0;
            st_q.trig  <= '0;
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o   = st_q.dir;
    assign drive_o = st_q.drive;
    assign pend_o  = st_q.flag & ~st_q.mask;

    always_comb begin
        case (sel)
            SEL_PEND:     rd_o = st_q.flag & ~st_q.mask;
            SEL_FLAGS:    rd_o = st_q.flag;
            SEL_MASK_CLR: rd_o = st_q.mask;
            SEL_DIR:      rd_o = st_q.dir;
            SEL_DRIVE:    rd_o = st_q.drive;
            SEL_SENSE:    rd_o = sync_in;
            SEL_TRIG:     rd_o = st_q.trig;
            default:      rd_o = '0;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter  int unsigned NUM_BANKS = 4,
    parameter  int unsigned BANK_W    = 8,
    parameter  int unsigned DATA_W    = 32,
    localparam int unsigned BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W    = OFF_W + BIDX_W,
    localparam int unsigned NUM_PINS  = NUM_BANKS * BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_dir,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq
);

    logic [NUM_PINS-1:0] sync_w;
    logic [NUM_PINS-1:0] pend_w;
    logic [BANK_W-1:0]   bank_rd [NUM_BANKS];
    logic [BIDX_W-1:0]   bank_idx;
    reg_sel_e            sel;

    assign bank_idx = addr[ADDR_W-1:OFF_W];
    assign sel      = decode_offset(addr[OFF_W-1:0]);

    pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && (bank_idx == BIDX_W'(b));

        pinbank_bank #(.LANES(BANK_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .sel     (sel),
            .wr_bits (wr_data[BANK_W-1:0]),
            .sync_in (sync_w[b*BANK_W +: BANK_W]),
            .dir_o   (pin_dir[b*BANK_W +: BANK_W]),
            .drive_o (pin_out[b*BANK_W +: BANK_W]),
            .pend_o  (pend_w[b*BANK_W +: BANK_W]),
            .rd_o    (bank_rd[b])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BIDX_W'(b)) rd_data[BANK_W-1:0] = bank_rd[b];
        end
    end

    assign irq = |pend_w;

endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker
    import pinbank_pkg::*;
#(
    parameter  int unsigned NUM_BANKS = 4,
    parameter  int unsigned BANK_W    = 8,
    parameter  int unsigned DATA_W    = 32,
    localparam int unsigned BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W    = OFF_W + BIDX_W,
    localparam int unsigned NUM_PINS  = NUM_BANKS * BANK_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] pin_dir,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                irq
);

    logic pad_write;
    assign pad_write = wr_en && (addr[OFF_W-1:0] == OFF_DIR || addr[OFF_W-1:0] == OFF_DRIVE);

    assert_reset_pads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_dir == '1 && pin_out == '0 && !irq));

    assert_pads_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_write |=> ($stable(pin_dir) && $stable(pin_out)));

    assert_quiet_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[OFF_W-1:0] == OFF_PEND && !irq) |-> rd_data == '0);

    assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:BANK_W] == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == {BIDX_W'(b), OFF_DIR})
            |=> pin_dir[b*BANK_W +: BANK_W] == $past(wr_data[BANK_W-1:0]));

        assert_drive_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == {BIDX_W'(b), OFF_DRIVE})
            |=> pin_out[b*BANK_W +: BANK_W] == $past(wr_data[BANK_W-1:0]));
    end

endmodule

bind pinbank_ctrl pinbank_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_dir (pin_dir),
    .pin_out (pin_out),
    .irq     (irq)
);

// File: tb/pinbank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_dir;
    logic [31:0] pin_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_dir(pin_dir), .pin_out(pin_out), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_dir, m_out, m_mask, m_flag, m_trig, m_last, m_s1, m_s2;
    logic [31:0] m_evt, m_clr, m_lane, m_lmask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '1; m_out = '0; m_mask = '1; m_flag = '0;
            m_trig = '0; m_last = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            m_evt = '0;
            for (int p = 0; p < 32; p++) begin
                if (m_trig[p] && m_s2[p]) m_evt[p] = 1'b1;
                if (!m_trig[p] && m_s2[p] && !m_last[p]) m_evt[p] = 1'b1;
            end
            m_clr = '0;
            if (wr_en) begin
                m_lane  = {24'b0, wr_data[7:0]} << (8 * addr[7:6]);
                m_lmask = 32'hFF << (8 * addr[7:6]);
                case (addr[5:0])
                    6'h04: m_clr = m_lane;
                    6'h08: m_mask = m_mask & ~m_lane;
                    6'h0C: m_mask = m_mask | m_lane;
                    6'h10: m_dir = (m_dir & ~m_lmask) | m_lane;
                    6'h14: m_out = (m_out & ~m_lmask) | m_lane;
                    6'h20: m_trig = (m_trig & ~m_lmask) | m_lane;
                    default: ;
                endcase
            end
            m_flag = (m_flag & ~m_clr) | m_evt;
            m_last = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int sh;
        sh = 8 * a[7:6];
        case (a[5:0])
            6'h00: return ((m_flag & ~m_mask) >> sh) & 32'hFF;
            6'h04: return (m_flag >> sh) & 32'hFF;
            6'h08: return (m_mask >> sh) & 32'hFF;
            6'h10: return (m_dir >> sh) & 32'hFF;
            6'h14: return (m_out >> sh) & 32'hFF;
            6'h18: return (m_s2 >> sh) & 32'hFF;
            6'h20: return (m_trig >> sh) & 32'hFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] off);
        case (off)
            6'h00: return "R10";
            6'h04: return "R8";
            6'h08: return "R9";
            6'h10: return "R3";
            6'h14: return "R4";
            6'h18: return "R5";
            6'h20: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R3 pin_dir", pin_dir, m_dir);
            chk("R4 pin_out", pin_out, m_out);
            chk("R11 irq", {31'b0, irq}, {31'b0, |(m_flag & ~m_mask)});
            chk(tag_of(addr[5:0]), rd_data, exp_rd(addr));
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            summary();
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; wr_en = 1'b0;
        #2;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        rd_chk(8'h10, 32'hFF, "R2 dir");
        rd_chk(8'h88, 32'hFF, "R2 mask");
        rd_chk(8'hC4, 32'h00, "R2 flags");
        rd_chk(8'h60, 32'h00, "R2 trig");
        chk("R2 pin_dir", pin_dir, 32'hFFFF_FFFF);
        chk("R2 pin_out", pin_out, 32'h0);
        chk("R2 irq", {31'b0, irq}, 32'h0);

        // R1 / R3 / R4 bank placement
        wr(8'h50, 32'h0000_000F);
        #2 chk("R1 R3 bank1 dir", pin_dir, 32'hFFFF_0FFF);
        wr(8'h94, 32'hFFFF_FFA5);
        #2 chk("R1 R4 bank2 out", pin_out, 32'h00A5_0000);
        rd_chk(8'h94, 32'hA5, "R12 upper bits");
        wr(8'hD4, 32'h3C);
        #2 chk("R1 R4 bank3 out", pin_out, 32'h3CA5_0000);

        // R5 synchroniser latency
        pin_in = 32'h1234_5678;
        addr = 8'h18;
        @(negedge clk);
        rd_chk(8'h18, 32'h00, "R5 one edge");
        @(negedge clk);
        rd_chk(8'h18, 32'h78, "R5 two edges");
        rd_chk(8'hD8, 32'h12, "R1 R5 bank3 sense");
        idle(2);

        // R6 clear under held-high input in edge mode stays clear
        for (int b = 0; b < 4; b++) wr(8'(b * 64 + 4), 32'hFF);
        idle(2);
        rd_chk(8'h44, 32'h00, "R6 stays clear");
        pin_in = 32'h1234_5679;
        idle(4);
        rd_chk(8'h04, 32'h01, "R6 rising edge");
        chk("R9 masked irq", {31'b0, irq}, 32'h0);

        // R9 / R10 / R11 masking
        wr(8'h08, 32'h01);
        #2 chk("R11 irq up", {31'b0, irq}, 32'h1);
        rd_chk(8'h00, 32'h01, "R10 pending");
        wr(8'h0C, 32'h01);
        #2 chk("R9 irq down", {31'b0, irq}, 32'h0);
        rd_chk(8'h08, 32'hFF, "R9 mask readback");
        rd_chk(8'h0C, 32'h00, "R9 set port reads zero");

        // R7 / R8 level mode, event beats clear
        wr(8'h60, 32'h02);
        wr(8'h44, 32'hFF);
        rd_chk(8'h44, 32'h02, "R7 R8 level re-set");
        idle(1);
        rd_chk(8'h44, 32'h02, "R7 level held");
        wr(8'h60, 32'h00);
        wr(8'h44, 32'hFF);
        idle(1);
        rd_chk(8'h44, 32'h00, "R8 cleared in edge mode");

        // R12 writes to read-only and unmapped offsets
        wr(8'h1C, 32'hFF); wr(8'h3C, 32'hFF); wr(8'h18, 32'hFF);
        wr(8'h00, 32'hFF); wr(8'h12, 32'hFF); wr(8'h11, 32'h00);
        rd_chk(8'h10, 32'hFF, "R12 dir untouched");
        rd_chk(8'h14, 32'h00, "R12 out untouched");
        rd_chk(8'h08, 32'hFF, "R12 mask untouched");
        rd_chk(8'h1C, 32'h00, "R12 unmapped read");
        rd_chk(8'h3C, 32'h00, "R12 unmapped read");

        // Mixed traffic checked by the per-cycle model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 2 == 0) addr = {2'($urandom % 4), 6'(($urandom % 9) * 4)};
            else                   addr = 8'($urandom);
            wr_en   = ($urandom % 3 == 0);
            wr_data = $urandom;
            if ($urandom % 3 == 0) pin_in = pin_in ^ (32'h1 << ($urandom % 32));
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
        summary();
    end

endmodule